// File: doc/BRIEF.md
# Registered ROM Programming-Port Mode Controller

This block is the programming side of a registered read-only store. It takes a program strobe, a verify strobe, a flag for the programming supply and flags for special levels on address pins. From these it picks one operating mode at a time. Writes go into a behavioural store. The store holds a flat data array followed by two hidden bytes: an initialize byte and a configuration byte. Read-back data is driven out with an output enable. Voltage levels appear only as digital flags.

Programming follows floating-gate cell rules. A bit starts at 0 in the erased state, and a program operation can only turn bits on. A separate erase input returns every location to the erased state, including both hidden bytes. The hidden bytes can be reached in two ways: through the flat address map, or through two special address-pin modes.

Top module: `romProgCtrl`

## Requirements
- R1: With `ADDR_W` = AW, flat addresses 0 to 2^AW-1 are array data, 2^AW is the initialize byte and 2^AW+1 is the configuration byte. Any higher address reads as 0x00, and a write to it changes nothing.
- R2: Program mode is selected by `progN`=0, `verifyN`=1, `hvPresent`=1 and `addrHvFlag`=0. At the next rising clock edge `dataIn` is written to the addressed location. `dataOe` is 0 in this mode.
- R3: A program operation stores the old byte OR `dataIn`, so a bit can only go from 0 to 1.
- R4: Verify mode is selected by `progN`=1, `verifyN`=0, `hvPresent`=1, `addrHvFlag`=0 and `blankReq`=0. The stored byte at the address is driven on `dataOut` with `dataOe`=1, and nothing is written.
- R5: Blank check uses the verify strobes with `blankReq`=1. It drives the stored byte with `dataOe`=1 and writes nothing, so an erased location reads 0x00.
- R6: With `hvPresent`=1 the mode is inhibit in three cases: both strobes are high, both strobes are low, or `addrHvFlag`=1 without the program strobe pattern. In inhibit, `dataOe`=0, `dataOut`=0 and nothing is written.
- R7: With `hvPresent`=1, `addrHvFlag`=1, `a3HiFlag`=1 and the program strobe pattern, the controller sets bit 0 of the configuration byte at the clock edge, and `dataOe` is 0.
- R8: With `hvPresent`=1, `addrHvFlag`=1, `a3HiFlag`=0 and the program strobe pattern, `dataIn` is ORed into the initialize byte at the clock edge, and `dataOe` is 0.
- R9: With `hvPresent`=0 the mode is read for any strobe levels. Nothing is written, and the byte at the address is driven with `dataOe`=1.
- R10: `eraseReq`=1 clears every location to 0x00 at the clock edge. Erase takes priority over any write in the same cycle.
- R11: `modeStatus` is one-hot. Bit 0 means read, 1 program, 2 verify, 3 inhibit, 4 blank check, 5 initialize-byte program and 6 configuration program.
- R12: Asynchronous active-low `rstN` puts the whole store into the erased state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and erase take effect on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset, erases the store |
| progN | input | 1 | Program strobe, active low |
| verifyN | input | 1 | Verify strobe, active low |
| hvPresent | input | 1 | Programming supply present |
| addrHvFlag | input | 1 | Address bit 0 held at supply level (special mode) |
| a3HiFlag | input | 1 | Address bit 3 at programming-high level (1) or low level (0) |
| blankReq | input | 1 | Turns a verify into a blank check |
| eraseReq | input | 1 | Erase all locations |
| addr | input | ADDR_W+1 | Flat programmer address |
| dataIn | input | 8 | Data to program |
| dataOut | output | 8 | Read-back byte, 0 while disabled |
| dataOe | output | 1 | Output enable for dataOut |
| modeStatus | output | 7 | One-hot decoded mode |

## Verification
The mode, `dataOe` and `dataOut` are combinational from the inputs and the current store, so they are due in the same cycle as the stimulus. The bench sets inputs just after a falling edge and samples one time unit later, before the next rising edge. Writes and erase land on the next rising edge and become visible right after it. The bench therefore updates its model at that edge and checks the written byte through a later verify or read cycle.

// File: rtl/romProgPkg.sv
package romProgPkg;

  typedef enum logic [6:0] {
    MODE_READ    = 7'b0000001,
    MODE_PROGRAM = 7'b0000010,
    MODE_VERIFY  = 7'b0000100,
    MODE_INHIBIT = 7'b0001000,
    MODE_BLANK   = 7'b0010000,
    MODE_INITPRG = 7'b0100000,
    MODE_SYNCPRG = 7'b1000000
  } progModeT;

  typedef enum logic [1:0] {
    TGT_FLAT = 2'd0,
    TGT_INIT = 2'd1,
    TGT_CFG  = 2'd2
  } wrTargetT;

  typedef struct packed {
    logic     wrEn;
    wrTargetT wrTarget;
    logic     driveOut;
  } ctrlStrobesT;

  localparam logic [7:0] CFG_SYNC_BIT = 8'h01;

endpackage

// File: rtl/romProgCtrl_decode.sv
module romProgCtrl_decode
  import romProgPkg::*;
(
  input  logic        progN,
  input  logic        verifyN,
  input  logic        hvPresent,
  input  logic        addrHvFlag,
  input  logic        a3HiFlag,
  input  logic        blankReq,
  output progModeT    mode,
  output ctrlStrobesT strobes
);

  logic progPattern;
  assign progPattern = !progN && verifyN;

  always_comb begin
    if (!hvPresent) begin
      mode = MODE_READ;
    end else if (addrHvFlag) begin
      if (progPattern) mode = a3HiFlag ? MODE_SYNCPRG : MODE_INITPRG;
      else             mode = MODE_INHIBIT;
    end else begin
      unique case ({progN, verifyN})
        2'b01:   mode = MODE_PROGRAM;
        2'b10:   mode = blankReq ? MODE_BLANK : MODE_VERIFY;
        default: mode = MODE_INHIBIT;
      endcase
    end
  end

  always_comb begin
    strobes.wrEn     = 1'b0;
    strobes.wrTarget = TGT_FLAT;
    strobes.driveOut = 1'b0;
    unique case (mode)
      MODE_PROGRAM: strobes.wrEn = 1'b1;
      MODE_INITPRG: begin strobes.wrEn = 1'b1; strobes.wrTarget = TGT_INIT; end
      MODE_SYNCPRG: begin strobes.wrEn = 1'b1; strobes.wrTarget = TGT_CFG;  end
      MODE_READ, MODE_VERIFY, MODE_BLANK: strobes.driveOut = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/romProgCtrl_store.sv
module romProgCtrl_store
  import romProgPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eraseReq,
  input  logic [ADDR_W:0]   addr,
  input  logic [7:0]        wrData,
  input  ctrlStrobesT       strobes,
  output logic [7:0]        rdOut,
  output logic              oe
);

  localparam int ARRAY_N  = 2 ** ADDR_W;
  localparam int DEPTH    = ARRAY_N + 2;
  localparam int INIT_IDX = ARRAY_N;
  localparam int CFG_IDX  = ARRAY_N + 1;

  logic [7:0] mem [DEPTH];
  logic       inRange;
  logic [7:0] rdRaw;
  logic [7:0] wrByte;
  int         wrIdx;
  logic       wrValid;

  assign inRange = (int'(addr) < DEPTH);
  assign rdRaw   = inRange ? mem[addr] : 8'h00;
  assign rdOut   = strobes.driveOut ? rdRaw : 8'h00;
  assign oe      = strobes.driveOut;

  always_comb begin
    wrByte  = wrData;
    wrIdx   = int'(addr);
    wrValid = strobes.wrEn && inRange;
    unique case (strobes.wrTarget)
      TGT_INIT: begin wrIdx = INIT_IDX; wrValid = strobes.wrEn; end
      TGT_CFG:  begin wrIdx = CFG_IDX;  wrValid = strobes.wrEn; wrByte = CFG_SYNC_BIT; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (eraseReq) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (wrValid) begin
      mem[wrIdx] <= mem[wrIdx] | wrByte;
    end
  end

  // R10: the cycle after an erase every location reads zero
  assert_erase_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |=> (rdRaw == 8'h00));

  // R3: without erase a location never loses a set bit
  assert_bits_only_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    !eraseReq |=> (!$stable(addr) || ((rdRaw & $past(rdRaw)) == $past(rdRaw))));

  // R6: no write strobe and no erase keeps the stored byte unchanged
  assert_hold_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.wrEn && !eraseReq) |=> (!$stable(addr) || $stable(rdRaw)));

endmodule

// File: rtl/romProgCtrl.sv
module romProgCtrl
  import romProgPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            progN,
  input  logic            verifyN,
  input  logic            hvPresent,
  input  logic            addrHvFlag,
  input  logic            a3HiFlag,
  input  logic            blankReq,
  input  logic            eraseReq,
  input  logic [ADDR_W:0] addr,
  input  logic [7:0]      dataIn,
  output logic [7:0]      dataOut,
  output logic            dataOe,
  output logic [6:0]      modeStatus
);

  progModeT    mode;
  ctrlStrobesT strobes;

  romProgCtrl_decode uDecode (
    .progN      (progN),
    .verifyN    (verifyN),
    .hvPresent  (hvPresent),
    .addrHvFlag (addrHvFlag),
    .a3HiFlag   (a3HiFlag),
    .blankReq   (blankReq),
    .mode       (mode),
    .strobes    (strobes)
  );

  romProgCtrl_store #(.ADDR_W(ADDR_W)) uStore (
    .clk      (clk),
    .rstN     (rstN),
    .eraseReq (eraseReq),
    .addr     (addr),
    .wrData   (dataIn),
    .strobes  (strobes),
    .rdOut    (dataOut),
    .oe       (dataOe)
  );

  assign modeStatus = mode;

  // R11: exactly one mode reported
  assert_mode_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(modeStatus));

  // R9: no programming supply means the output is enabled
  assert_no_hv_reads_R9: assert property (@(posedge clk) disable iff (!rstN)
    !hvPresent |-> dataOe);

  // R6: inhibit keeps the data pins released
  assert_inhibit_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    modeStatus[3] |-> (!dataOe && dataOut == 8'h00));

  // R2: program mode never drives the pins
  assert_program_no_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    modeStatus[1] |-> !dataOe);

endmodule

// File: tb/romProgCtrl_test.sv
module romProgCtrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 4;
  localparam int NARR  = 2 ** AW;
  localparam int DEPTH = NARR + 2;
  localparam int NADDR = 2 ** (AW + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progN = 1'b1, verifyN = 1'b1, hvPresent = 1'b0;
  logic addrHvFlag = 1'b0, a3HiFlag = 1'b0, blankReq = 1'b0, eraseReq = 1'b0;
  logic [AW:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOe;
  logic [6:0] modeStatus;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] model [NADDR];

  romProgCtrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .progN(progN), .verifyN(verifyN),
    .hvPresent(hvPresent), .addrHvFlag(addrHvFlag), .a3HiFlag(a3HiFlag),
    .blankReq(blankReq), .eraseReq(eraseReq), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .modeStatus(modeStatus)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic checkEq(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  function automatic logic [6:0] expMode(input logic p, input logic v, input logic hv,
                                         input logic ahv, input logic a3, input logic bl);
    if (!hv) return 7'b0000001;
    if (ahv) begin
      if (p == 1'b0 && v == 1'b1) return a3 ? 7'b1000000 : 7'b0100000;
      return 7'b0001000;
    end
    if (p == 1'b0 && v == 1'b1) return 7'b0000010;
    if (p == 1'b1 && v == 1'b0) return bl ? 7'b0010000 : 7'b0000100;
    return 7'b0001000;
  endfunction

  function automatic string tagOf(input logic [6:0] m);
    case (m)
      7'b0000001: return "R9";
      7'b0000010: return "R2";
      7'b0000100: return "R4";
      7'b0001000: return "R6";
      7'b0010000: return "R5";
      7'b0100000: return "R8";
      default:    return "R7";
    endcase
  endfunction

  // one cycle: drive after falling edge, check combinational outputs, update model at rising edge
  task automatic step(input logic p, input logic v, input logic hv, input logic ahv,
                      input logic a3, input logic bl, input logic er,
                      input int a, input logic [7:0] d);
    logic [6:0] m;
    logic drive;
    string tag;
    @(negedge clk);
    progN = p; verifyN = v; hvPresent = hv; addrHvFlag = ahv;
    a3HiFlag = a3; blankReq = bl; eraseReq = er;
    addr = a[AW:0]; dataIn = d;
    #1;
    m = expMode(p, v, hv, ahv, a3, bl);
    tag = tagOf(m);
    drive = (m == 7'b0000001) || (m == 7'b0000100) || (m == 7'b0010000);
    checkEq({tag, "_R11 status"}, int'(modeStatus), int'(m));
    checkEq({tag, " oe"}, int'(dataOe), int'(drive));
    checkEq({tag, "_R1 data"}, int'(dataOut), drive ? int'(model[a]) : 0);
    @(posedge clk);
    if (er) begin
      for (int i = 0; i < NADDR; i++) model[i] = 8'h00;
    end else if (m == 7'b0000010) begin
      if (a < DEPTH) model[a] = model[a] | d;
    end else if (m == 7'b0100000) begin
      model[NARR] = model[NARR] | d;
    end else if (m == 7'b1000000) begin
      model[NARR + 1] = model[NARR + 1] | 8'h01;
    end
  endtask

  task automatic verifyAll(input logic bl);
    for (int a = 0; a < NADDR; a++) step(1, 0, 1, 0, 0, bl, 0, a, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < NADDR; i++) model[i] = 8'h00;
    repeat (2) @(posedge clk);
    #1;
    // R12: after reset, read mode with erased byte
    checkEq("R12 status", int'(modeStatus), 1);
    checkEq("R12 data", int'(dataOut), 0);
    checkEq("R12 oe", int'(dataOe), 1);
    @(negedge clk);
    rstN = 1'b1;
    // R12/R5: whole store erased after reset
    verifyAll(1);
    // R1/R2: program every flat address, including those past the map
    for (int a = 0; a < NADDR; a++) step(0, 1, 1, 0, 0, 0, 0, a, 8'((a * 37 + 5) & 8'hF0));
    verifyAll(0);
    // R3: second pass only adds bits
    for (int a = 0; a < NADDR; a++) step(0, 1, 1, 0, 0, 0, 0, a, 8'((a * 11) & 8'h0F));
    verifyAll(0);
    for (int a = 0; a < NADDR; a++) step(0, 1, 1, 0, 0, 0, 0, a, 8'h00);
    verifyAll(0);
    // R6..R9, R11: sweep every control combination
    for (int c = 0; c < 64; c++)
      step(c[0], c[1], c[2], c[3], c[4], c[5], 0, (c * 7) % NADDR, 8'(c * 3));
    verifyAll(0);
    // R10: erase beats a simultaneous program
    step(0, 1, 1, 0, 0, 0, 1, 3, 8'hFF);
    verifyAll(1);
    // R8: initialize byte through the special mode
    step(0, 1, 1, 1, 0, 0, 0, 0, 8'h5A);
    step(0, 1, 1, 1, 0, 0, 0, 5, 8'h81);
    step(1, 0, 1, 0, 0, 0, 0, NARR, 8'h00);
    checkEq("R8 init byte", int'(model[NARR]), 8'hDB);
    // R7: configuration byte set to synchronous
    step(0, 1, 1, 1, 1, 0, 0, 0, 8'hF0);
    step(1, 0, 1, 0, 0, 0, 0, NARR + 1, 8'h00);
    checkEq("R7 cfg byte", int'(model[NARR + 1]), 1);
    // R9: no supply, program strobes do nothing
    step(0, 1, 0, 0, 0, 0, 0, 2, 8'hFF);
    step(1, 0, 1, 0, 0, 0, 0, 2, 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule